// File: doc/BRIEF.md
# SPI Command Front-End for a Serial Byte Memory

This block is the serial slave of a byte-wide memory. It oversamples a mode-0 SPI bus with the system clock. It collects an 8-bit instruction, MSB first, and decodes it. It then either streams array data out of a synchronous memory port, gathers array write data, or forwards latch, flag and status-register requests to a separate status/protection block. Address and data bytes also travel MSB first. After a read or write instruction, a big-endian address of `ADDR_BYTES` bytes follows, and the address steps by one for each later data byte.

Array writes are never performed while the frame is in progress. Write bytes are held in a small local buffer. They are released only when chip select rises on a byte boundary while `write_allow` (the verdict of the external protection logic) is high. The buffer then drains over a valid/ready port. During back-pressure, the port holds its address and data unchanged until a transfer completes. A frame that begins while the drain is still running is ignored.

SCK, chip select and SI are brought into the system clock domain through a synchroniser chain. Each SCK high and low phase must therefore last at least four system clocks. SCK may be stopped for any length of time without losing state.

Top module: `spi_cmd_frontend`

## Requirements
- R1: After reset, `spi_miso_oe`, `spi_miso`, `mem_wr_valid`, `mem_rd_en` and all request pulses are low.
- R2: SI is taken on rising SCK edges while chip select is low, MSB first. The first 8 bits form the opcode: 0x06 sets the latch, 0x04 clears the latch and flag, 0x00 sets the flag, 0x05 reads status, 0x01 writes status, 0x03 reads the array and 0x02 writes the array.
- R3: A one-cycle request is raised when chip select rises after exactly 8 bits of opcode 0x06 (`ctl_wel_set`), 0x04 (`ctl_wel_clr`) or 0x00 (`ctl_flag_set`). A frame with fewer or more bits raises none. At most one request pulse is high in any cycle.
- R4: After opcode 0x05, `status_byte` is shifted out MSB first on SO, one bit per falling SCK edge, repeatedly for as long as clocking continues. Each byte is sampled when the previous byte slot ends. `spi_miso_oe` falls after chip select rises.
- R5: After opcode 0x03 and a 16-bit address, bytes are read from that address upward, with the address wrapping from 0xFFFF to 0x0000. Each byte is requested on `mem_rd_en`/`mem_rd_addr` and returned on `mem_rd_data` one cycle later.
- R6: After opcode 0x02 and the address, buffered bytes are written to consecutive addresses only if chip select rises on a byte boundary with `write_allow` high. A trailing partial byte, or `write_allow` low, cancels every write of the frame.
- R7: While `mem_wr_valid` is high and `mem_wr_ready` is low, `mem_wr_addr` and `mem_wr_data` hold. A transfer happens on each cycle where both are high.
- R8: After opcode 0x01, when chip select rises on a byte boundary with at least one data byte received, `stat_wr_valid` pulses once with the last complete byte on `stat_wr_data`.
- R9: An unrecognised opcode causes no memory access and no request, and `spi_miso_oe` stays low until chip select rises.
- R10: SCK may pause indefinitely in the middle of a frame, and the transfer continues correctly when it restarts.
- R11: Write bytes beyond `WBUF_DEPTH` in one frame are discarded. Only the first `WBUF_DEPTH` bytes are written.
- R12: A frame whose chip select falls while buffered writes are still draining is ignored in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in (SI) |
| spi_miso | output | 1 | Serial data out (SO), low when not enabled |
| spi_miso_oe | output | 1 | SO output enable |
| mem_rd_en | output | 1 | Array read strobe |
| mem_rd_addr | output | ADDR_W | Array read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the strobe |
| mem_wr_valid | output | 1 | Write transfer offered |
| mem_wr_ready | input | 1 | Write transfer accepted |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | 8 | Write data |
| write_allow | input | 1 | Protection verdict, sampled as chip select rises |
| status_byte | input | 8 | Current status register contents |
| ctl_wel_set | output | 1 | Pulse: set write-enable latch |
| ctl_wel_clr | output | 1 | Pulse: clear write-enable latch and flag |
| ctl_flag_set | output | 1 | Pulse: set flag bit |
| stat_wr_valid | output | 1 | Pulse: status register write |
| stat_wr_data | output | 8 | Status register write value |

## Verification
The hardest case to reach is a frame that arrives while a committed write is still draining. Buffered writes normally empty within a few system clocks of chip select rising. The bench therefore holds `mem_wr_ready` low after committing a write frame. It then sends a complete latch-set frame into the stalled window and checks that no request pulse appears. Only after that does it release the port and count the writes. Wrap-around reads, a trailing partial write byte and a long SCK pause in the middle of an address are each driven by dedicated bit-level tasks.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_SFLB  = 8'h00;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_ADDR,
    PH_DATA,
    PH_SKIP
  } phase_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_LATCH_ON,
    CMD_LATCH_OFF,
    CMD_FLAG_ON,
    CMD_STAT_RD,
    CMD_STAT_WR,
    CMD_ARR_RD,
    CMD_ARR_WR
  } cmd_e;

  function automatic cmd_e decode_op(input logic [7:0] op);
    case (op)
      OP_WREN:  decode_op = CMD_LATCH_ON;
      OP_WRDI:  decode_op = CMD_LATCH_OFF;
      OP_SFLB:  decode_op = CMD_FLAG_ON;
      OP_RDSR:  decode_op = CMD_STAT_RD;
      OP_WRSR:  decode_op = CMD_STAT_WR;
      OP_READ:  decode_op = CMD_ARR_RD;
      OP_WRITE: decode_op = CMD_ARR_WR;
      default:  decode_op = CMD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic cs_n_in,
  input  logic mosi_in,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_bit,
  output logic cs_active,
  output logic cs_start,
  output logic cs_end
);

  logic [STAGES-1:0] sck_q, cs_q, mosi_q;
  logic sck_prev, cs_prev;
  logic sck_s, cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= '0;
      cs_q     <= '1;
      mosi_q   <= '0;
      sck_prev <= 1'b0;
      cs_prev  <= 1'b1;
    end else begin
      sck_q    <= {sck_q[STAGES-2:0], sck_in};
      cs_q     <= {cs_q[STAGES-2:0], cs_n_in};
      mosi_q   <= {mosi_q[STAGES-2:0], mosi_in};
      sck_prev <= sck_s;
      cs_prev  <= cs_s;
    end
  end

  assign sck_s     = sck_q[STAGES-1];
  assign cs_s      = cs_q[STAGES-1];
  assign mosi_bit  = mosi_q[STAGES-1];
  assign sck_rise  = sck_s & ~sck_prev;
  assign sck_fall  = ~sck_s & sck_prev;
  assign cs_active = ~cs_s;
  assign cs_start  = ~cs_s & cs_prev;
  assign cs_end    = cs_s & ~cs_prev;

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_end,
  input  logic       load_en,
  input  logic [7:0] load_byte,
  input  logic       shift_en,
  output logic       miso,
  output logic       miso_oe
);

  logic [7:0] tx_byte;
  logic [2:0] out_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte <= '0;
      out_idx <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else if (frame_end) begin
      out_idx <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      if (load_en) begin
        tx_byte <= load_byte;
        out_idx <= '0;
      end else if (shift_en) begin
        miso    <= tx_byte[3'd7 - out_idx];
        out_idx <= out_idx + 3'd1;
        miso_oe <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_wr_buffer.sv
module spi_wr_buffer #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic [7:0]        push_data,
  input  logic              base_load,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              commit,
  output logic              busy,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [7:0]        store [DEPTH];
  logic [CNT_W-1:0]  count;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base_q;
  logic              last_xfer;

  assign last_xfer = (CNT_W'(idx) + CNT_W'(1)) == count;

  always_ff @(posedge clk) begin
    if (push && !busy && count < CNT_W'(DEPTH))
      store[count[IDX_W-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      idx    <= '0;
      base_q <= '0;
      busy   <= 1'b0;
    end else if (busy) begin
      if (wr_ready) begin
        if (last_xfer) begin
          busy  <= 1'b0;
          count <= '0;
          idx   <= '0;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end else if (clear) begin
      count <= '0;
      idx   <= '0;
    end else begin
      if (base_load) base_q <= base_addr;
      if (push && count < CNT_W'(DEPTH)) count <= count + CNT_W'(1);
      if (commit && count != '0) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end
  end

  assign wr_valid = busy;
  assign wr_addr  = base_q + ADDR_W'(idx);
  assign wr_data  = store[idx];

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R11
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_BYTES  = 2,
  parameter int WBUF_DEPTH  = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data,
  input  logic              write_allow,
  input  logic [7:0]        status_byte,
  output logic              ctl_wel_set,
  output logic              ctl_wel_clr,
  output logic              ctl_flag_set,
  output logic              stat_wr_valid,
  output logic [7:0]        stat_wr_data
);

  localparam int ACNT_W = $clog2(ADDR_BYTES + 1);

  logic sck_rise, sck_fall, mosi_bit, cs_active, cs_start, cs_end;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sck_in(spi_sck), .cs_n_in(spi_cs_n), .mosi_in(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_bit(mosi_bit),
    .cs_active(cs_active), .cs_start(cs_start), .cs_end(cs_end)
  );

  phase_e            phase;
  cmd_e              cmd;
  logic [2:0]        bit_idx;
  logic [7:0]        shreg;
  logic [ADDR_W-1:0] addr_q;
  logic [ACNT_W-1:0] abyte;
  logic              extra, out_mode, stat_load, rd_pending;
  logic [7:0]        wrsr_byte;
  logic              wrsr_have;
  logic              buf_busy;

  logic [7:0]        rx_byte;
  logic [ADDR_W+7:0] addr_cat;
  logic [ADDR_W-1:0] addr_next;
  logic              bit_ok, byte_done, last_abyte;

  assign rx_byte    = {shreg[6:0], mosi_bit};
  assign addr_cat   = {addr_q, rx_byte};
  assign addr_next  = addr_cat[ADDR_W-1:0];
  assign bit_ok     = sck_rise && cs_active && !cs_start && phase != PH_SKIP;
  assign byte_done  = bit_ok && bit_idx == 3'd7;
  assign last_abyte = abyte == ACNT_W'(ADDR_BYTES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase         <= PH_SKIP;
      cmd           <= CMD_NONE;
      bit_idx       <= '0;
      shreg         <= '0;
      addr_q        <= '0;
      abyte         <= '0;
      extra         <= 1'b0;
      out_mode      <= 1'b0;
      stat_load     <= 1'b0;
      rd_pending    <= 1'b0;
      wrsr_byte     <= '0;
      wrsr_have     <= 1'b0;
      mem_rd_en     <= 1'b0;
      mem_rd_addr   <= '0;
      ctl_wel_set   <= 1'b0;
      ctl_wel_clr   <= 1'b0;
      ctl_flag_set  <= 1'b0;
      stat_wr_valid <= 1'b0;
      stat_wr_data  <= '0;
    end else begin
      ctl_wel_set   <= 1'b0;
      ctl_wel_clr   <= 1'b0;
      ctl_flag_set  <= 1'b0;
      stat_wr_valid <= 1'b0;
      stat_load     <= 1'b0;
      mem_rd_en     <= 1'b0;
      rd_pending    <= mem_rd_en;
      if (cs_start) begin
        phase     <= buf_busy ? PH_SKIP : PH_CMD;
        cmd       <= CMD_NONE;
        bit_idx   <= '0;
        abyte     <= '0;
        extra     <= 1'b0;
        out_mode  <= 1'b0;
        wrsr_have <= 1'b0;
      end else if (cs_end) begin
        if (phase == PH_DATA && bit_idx == 3'd0) begin
          case (cmd)
            CMD_LATCH_ON:  ctl_wel_set  <= !extra;
            CMD_LATCH_OFF: ctl_wel_clr  <= !extra;
            CMD_FLAG_ON:   ctl_flag_set <= !extra;
            CMD_STAT_WR: begin
              stat_wr_valid <= wrsr_have;
              stat_wr_data  <= wrsr_byte;
            end
            default: ;
          endcase
        end
        phase    <= PH_SKIP;
        out_mode <= 1'b0;
      end else if (bit_ok) begin
        shreg   <= rx_byte;
        bit_idx <= bit_idx + 3'd1;
        if (phase == PH_DATA) extra <= 1'b1;
        if (bit_idx == 3'd7) begin
          case (phase)
            PH_CMD: begin
              cmd <= decode_op(rx_byte);
              case (decode_op(rx_byte))
                CMD_NONE:              phase <= PH_SKIP;
                CMD_ARR_RD, CMD_ARR_WR: phase <= PH_ADDR;
                CMD_STAT_RD: begin
                  phase     <= PH_DATA;
                  stat_load <= 1'b1;
                  out_mode  <= 1'b1;
                end
                default:               phase <= PH_DATA;
              endcase
            end
            PH_ADDR: begin
              addr_q <= addr_next;
              abyte  <= abyte + ACNT_W'(1);
              if (last_abyte) begin
                phase <= PH_DATA;
                if (cmd == CMD_ARR_RD) begin
                  mem_rd_en   <= 1'b1;
                  mem_rd_addr <= addr_next;
                  addr_q      <= addr_next + ADDR_W'(1);
                  out_mode    <= 1'b1;
                end
              end
            end
            PH_DATA: begin
              case (cmd)
                CMD_ARR_RD: begin
                  mem_rd_en   <= 1'b1;
                  mem_rd_addr <= addr_q;
                  addr_q      <= addr_q + ADDR_W'(1);
                end
                CMD_STAT_RD: stat_load <= 1'b1;
                CMD_STAT_WR: begin
                  wrsr_byte <= rx_byte;
                  wrsr_have <= 1'b1;
                end
                default: ;
              endcase
            end
            default: ;
          endcase
        end
      end
    end
  end

  logic buf_push, buf_base, buf_commit, buf_clear;

  assign buf_push   = byte_done && phase == PH_DATA && cmd == CMD_ARR_WR;
  assign buf_base   = byte_done && phase == PH_ADDR && last_abyte && cmd == CMD_ARR_WR;
  assign buf_commit = cs_end && phase == PH_DATA && cmd == CMD_ARR_WR &&
                      bit_idx == 3'd0 && write_allow;
  assign buf_clear  = cs_start;

  spi_wr_buffer #(.ADDR_W(ADDR_W), .DEPTH(WBUF_DEPTH)) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .clear(buf_clear), .push(buf_push), .push_data(rx_byte),
    .base_load(buf_base), .base_addr(addr_next), .commit(buf_commit),
    .busy(buf_busy),
    .wr_valid(mem_wr_valid), .wr_ready(mem_wr_ready),
    .wr_addr(mem_wr_addr), .wr_data(mem_wr_data)
  );

  logic       tx_load;
  logic [7:0] tx_byte_in;

  assign tx_load    = rd_pending | stat_load;
  assign tx_byte_in = rd_pending ? mem_rd_data : status_byte;

  spi_tx_shift u_tx (
    .clk(clk), .rst_n(rst_n),
    .frame_end(cs_end), .load_en(tx_load), .load_byte(tx_byte_in),
    .shift_en(sck_fall && out_mode && cs_active),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  // R3
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_wel_set, ctl_wel_clr, ctl_flag_set, stat_wr_valid}));

  // R3
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wel_set |=> !ctl_wel_set);

  // R5
  rd_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R4
  oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end |=> !spi_miso_oe);

  // R12
  busy_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_start && buf_busy |=> phase == PH_SKIP);

endmodule

// File: tb/sim_spi_cmd_frontend.sv
module sim_spi_cmd_frontend;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int AW         = 16;
  localparam int DEPTH      = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [7:0] mem_rd_data = '0;
  logic mem_wr_valid;
  logic mem_wr_ready = 1'b0;
  logic [AW-1:0] mem_wr_addr;
  logic [7:0] mem_wr_data;
  logic write_allow = 1'b1;
  logic [7:0] status_byte = 8'hA5;
  logic ctl_wel_set, ctl_wel_clr, ctl_flag_set, stat_wr_valid;
  logic [7:0] stat_wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_frontend u0 (
    .clk(clk), .rst_n(rst_n),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .write_allow(write_allow), .status_byte(status_byte),
    .ctl_wel_set(ctl_wel_set), .ctl_wel_clr(ctl_wel_clr),
    .ctl_flag_set(ctl_flag_set), .stat_wr_valid(stat_wr_valid),
    .stat_wr_data(stat_wr_data)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [7:0] ram [256];
  int rd_n = 0, wr_n = 0;
  logic [AW-1:0] rd_log [16];
  logic [AW-1:0] wr_log_a [32];
  logic [7:0] wr_log_d [32];
  int n_set = 0, n_clr = 0, n_flag = 0, n_stat = 0;
  logic [7:0] last_stat = '0;
  bit oe_seen = 0;
  bit ready_hold = 0;

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  initial for (int i = 0; i < 256; i++) ram[i] = init_val(i);

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= ram[mem_rd_addr[7:0]];
      if (rd_n < 16) rd_log[rd_n] <= mem_rd_addr;
      rd_n <= rd_n + 1;
    end
    if (mem_wr_valid && mem_wr_ready) begin
      ram[mem_wr_addr[7:0]] <= mem_wr_data;
      if (wr_n < 32) begin
        wr_log_a[wr_n] <= mem_wr_addr;
        wr_log_d[wr_n] <= mem_wr_data;
      end
      wr_n <= wr_n + 1;
    end
    if (ctl_wel_set) n_set <= n_set + 1;
    if (ctl_wel_clr) n_clr <= n_clr + 1;
    if (ctl_flag_set) n_flag <= n_flag + 1;
    if (stat_wr_valid) begin
      n_stat <= n_stat + 1;
      last_stat <= stat_wr_data;
    end
    if (spi_miso_oe) oe_seen <= 1'b1;
  end

  always @(negedge clk) mem_wr_ready <= ready_hold ? 1'b0 : ~mem_wr_ready;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cs_low();
    spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_high();
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - n; b--) begin
      spi_mosi = tx[b];
      wait_clk(HALF);
      rx[b] = spi_miso;
      spi_sck = 1'b1;
      wait_clk(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic clear_logs();
    wait_clk(2);
    rd_n = 0; wr_n = 0; oe_seen = 0;
  endtask

  task automatic t_reset();
    chk(spi_miso_oe === 1'b0, "R1 oe", 32'(spi_miso_oe), 0);
    chk(spi_miso === 1'b0, "R1 miso", 32'(spi_miso), 0);
    chk(mem_wr_valid === 1'b0 && mem_rd_en === 1'b0, "R1 mem",
        32'({mem_wr_valid, mem_rd_en}), 0);
    chk({ctl_wel_set, ctl_wel_clr, ctl_flag_set, stat_wr_valid} === 4'b0, "R1 pulses",
        32'({ctl_wel_set, ctl_wel_clr, ctl_flag_set, stat_wr_valid}), 0);
  endtask

  task automatic t_single_cmds();
    logic [7:0] rx;
    int s0, c0, f0;
    s0 = n_set; c0 = n_clr; f0 = n_flag;
    cs_low(); xbyte(8'h06, rx); cs_high();
    chk(n_set == s0 + 1, "R2 R3 latch set", n_set - s0, 1);
    cs_low(); xbyte(8'h04, rx); cs_high();
    chk(n_clr == c0 + 1, "R3 latch clear", n_clr - c0, 1);
    cs_low(); xbyte(8'h00, rx); cs_high();
    chk(n_flag == f0 + 1, "R3 flag set", n_flag - f0, 1);
    cs_low(); xbyte(8'h06, rx); xbits(8'hFF, 3, rx); cs_high();
    chk(n_set == s0 + 1, "R3 extra bits", n_set - s0, 1);
    cs_low(); xbits(8'h06, 5, rx); cs_high();
    chk(n_set == s0 + 1, "R3 short frame", n_set - s0, 1);
  endtask

  task automatic t_status_read();
    logic [7:0] r0, r1, r2, r3, rx;
    status_byte = 8'hA5;
    cs_low(); xbyte(8'h05, rx); xbyte(8'h00, r0); xbyte(8'h00, r1);
    status_byte = 8'h3C;
    xbyte(8'h00, r2); xbyte(8'h00, r3); cs_high();
    chk(r0 == 8'hA5, "R4 status byte0", r0, 8'hA5);
    chk(r1 == 8'hA5, "R4 status byte1", r1, 8'hA5);
    chk(r3 == 8'h3C, "R4 status refresh", r3, 8'h3C);
    chk(spi_miso_oe === 1'b0, "R4 oe release", 32'(spi_miso_oe), 0);
  endtask

  task automatic t_array_read(input logic [15:0] a, input bit pause);
    logic [7:0] d0, d1, d2, rx;
    clear_logs();
    cs_low(); xbyte(8'h03, rx); xbyte(a[15:8], rx);
    if (pause) wait_clk(400);
    xbyte(a[7:0], rx);
    xbyte(8'h00, d0); xbyte(8'h00, d1); xbyte(8'h00, d2); cs_high();
    if (pause) begin
      chk(d0 == init_val(int'(a[7:0])), "R10 paused read", d0, init_val(int'(a[7:0])));
    end else begin
      chk(d0 == init_val(int'(a[7:0])), "R5 read byte0", d0, init_val(int'(a[7:0])));
      chk(d1 == init_val(int'(8'(a[7:0] + 1))), "R5 read byte1", d1,
          init_val(int'(8'(a[7:0] + 1))));
      chk(d2 == init_val(int'(8'(a[7:0] + 2))), "R5 read byte2", d2,
          init_val(int'(8'(a[7:0] + 2))));
      chk(rd_log[1] == 16'(a + 1), "R5 address step", rd_log[1], 16'(a + 1));
    end
  endtask

  task automatic t_unknown();
    logic [7:0] rx;
    int s0;
    s0 = n_set + n_clr + n_flag + n_stat;
    clear_logs();
    cs_low(); xbyte(8'h9A, rx); xbyte(8'h06, rx); xbyte(8'h03, rx); cs_high();
    chk(oe_seen == 0, "R9 oe stays low", 32'(oe_seen), 0);
    chk(rd_n == 0 && wr_n == 0, "R9 no memory access", rd_n + wr_n, 0);
    chk(n_set + n_clr + n_flag + n_stat == s0, "R9 no request",
        n_set + n_clr + n_flag + n_stat - s0, 0);
  endtask

  task automatic t_write(input logic [15:0] a, input int n, input bit allow,
                         input bit partial, input int exp_n, input string tag);
    logic [7:0] rx;
    clear_logs();
    write_allow = allow;
    cs_low(); xbyte(8'h02, rx); xbyte(a[15:8], rx); xbyte(a[7:0], rx);
    for (int i = 0; i < n; i++) xbyte(8'(8'hC0 + i), rx);
    if (partial) xbits(8'hFF, 4, rx);
    cs_high();
    wait_clk(40);
    write_allow = 1'b1;
    chk(wr_n == exp_n, tag, wr_n, exp_n);
    for (int i = 0; i < exp_n && i < 32; i++) begin
      chk(wr_log_a[i] == 16'(a + i) && wr_log_d[i] == 8'(8'hC0 + i), tag,
          {wr_log_a[i], wr_log_d[i]}, {16'(a + i), 8'(8'hC0 + i)});
    end
  endtask

  task automatic t_status_write();
    logic [7:0] rx;
    int s0;
    s0 = n_stat;
    cs_low(); xbyte(8'h01, rx); xbyte(8'h8C, rx); cs_high();
    chk(n_stat == s0 + 1 && last_stat == 8'h8C, "R8 status write",
        {n_stat - s0, last_stat}, {32'd1, 8'h8C});
    cs_low(); xbyte(8'h01, rx); xbyte(8'h11, rx); xbyte(8'h72, rx); cs_high();
    chk(n_stat == s0 + 2 && last_stat == 8'h72, "R8 last byte",
        {n_stat - s0, last_stat}, {32'd2, 8'h72});
    cs_low(); xbyte(8'h01, rx); xbyte(8'h33, rx); xbits(8'hFF, 2, rx); cs_high();
    chk(n_stat == s0 + 2, "R8 partial byte", n_stat - s0, 2);
  endtask

  task automatic t_busy_frame();
    logic [7:0] rx;
    int s0;
    clear_logs();
    ready_hold = 1;
    s0 = n_set;
    cs_low(); xbyte(8'h02, rx); xbyte(8'h00, rx); xbyte(8'h60, rx);
    xbyte(8'hC0, rx); xbyte(8'hC1, rx); cs_high();
    cs_low(); xbyte(8'h06, rx); cs_high();
    chk(n_set == s0, "R12 frame during drain", n_set - s0, 0);
    chk(wr_n == 0, "R7 stalled port", wr_n, 0);
    ready_hold = 0;
    wait_clk(40);
    chk(wr_n == 2 && wr_log_a[1] == 16'h0061 && wr_log_d[1] == 8'hC1, "R7 R12 drain",
        {wr_n, wr_log_a[1], wr_log_d[1]}, {32'd2, 16'h0061, 8'hC1});
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_single_cmds();
    t_status_read();
    t_array_read(16'h0010, 0);
    t_array_read(16'hFFFF, 0);
    chk(rd_log[0] == 16'hFFFF && rd_log[1] == 16'h0000, "R5 wrap",
        {rd_log[0], rd_log[1]}, {16'hFFFF, 16'h0000});
    t_array_read(16'h0025, 1);
    t_unknown();
    t_write(16'h0040, 3, 1, 0, 3, "R6 R7 write commit");
    t_write(16'h0050, 3, 0, 0, 0, "R6 protected");
    t_write(16'h0050, 3, 1, 1, 0, "R6 partial byte");
    t_write(16'h0080, 10, 1, 0, DEPTH, "R11 overflow");
    t_status_write();
    t_busy_frame();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule